// File: doc/BRIEF.md
# Vertical Active Window Generator

This block belongs to a raster display timing engine. It keeps a vertical line counter that runs downward, one step per end-of-line strobe. When the counter reaches zero, the next strobe reloads it from a programmable line total. Two programmed counter values mark where the vertical-active window opens and where it closes. The window is a registered flag. A second registered output follows the same open and close points as a vertical sync pulse, but only when sync output is switched on and the composite-sync mode is off. The window flag is ORed with a horizontal-active input to give the active-video qualifier.

Software programs the block through a small register port. Every value written can be read back at once. The block only uses new values at the next counter reload, so a frame that is already running never sees a half-changed window.

Top module: `vwin_top`

## Requirements
- R1: After reset, `vActive`, `vSync` and every register read back as zero, and the line counter holds zero.
- R2: The window flag `vActive` is set one clock after the line counter equals the in-use start value, held in bits [CNT_W-1:0] of register address 0.
- R3: `vActive` is cleared one clock after the line counter equals the in-use stop value, held in bits [16+CNT_W-1:16] of register address 0.
- R4: When the in-use start and stop values are equal, `vActive` and `vSync` never change from the state they already hold.
- R5: The mode register is at address 2: bit 0 enables sync output and bit 1 selects composite sync. When bit 0 is 1 and bit 1 is 0, `vSync` is set on a start match and cleared on a stop match. In any other mode, `vSync` is held at 0.
- R6: `videoActive` is the OR of `vActive` and `hActive` on every cycle.
- R7: Bits outside the defined fields of every register read back as zero, and writes to them are ignored.
- R8: A register write is visible on read-back in the next cycle. The window, the mode and the line total only come into use at the next counter reload.
- R9: Each `lineEnd` pulse decrements a nonzero line counter by one. A pulse when the counter is zero loads the line total, held in bits [CNT_W-1:0] of address 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 2 | Register address (0 window, 1 line total, 2 mode) |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Combinational read data for `regAddr` |
| lineEnd | input | 1 | End-of-line strobe, one cycle wide |
| hActive | input | 1 | Horizontal active qualifier from the line timing |
| vActive | output | 1 | Registered vertical-active window flag |
| vSync | output | 1 | Registered, mode-gated vertical sync |
| videoActive | output | 1 | OR of `vActive` and `hActive` |

## Verification
The assertions check on every cycle how the counter moves on each strobe (reload or decrement) and how each output flop responds to the compare strobes. They also check that `vSync` stays low while the sync gate is closed and that reserved read-back bits are zero. Only the bench scenarios can show the behaviour across whole frames. That includes where the window opens and closes for every start and stop pair within a small line total, that a write made in the middle of a frame has no effect until the reload, and that `vSync` follows all four mode encodings.

// File: rtl/vwin_pkg.sv
package vwin_pkg;

  // Register addresses
  localparam logic [1:0] ADDR_WINDOW = 2'd0;
  localparam logic [1:0] ADDR_TOTAL  = 2'd1;
  localparam logic [1:0] ADDR_MODE   = 2'd2;

  // Bit position of the stop field inside the window register
  localparam int STOP_LSB = 16;

  // Strobes from control to datapath
  typedef struct packed {
    logic load;      // counter reload this cycle
    logic step;      // counter decrement this cycle
    logic startHit;  // counter equals in-use start, window valid
    logic stopHit;   // counter equals in-use stop, window valid
    logic syncGate;  // sync output allowed by in-use mode
  } vwin_strobe_t;

endpackage

// File: rtl/vwin_ctrl.sv
module vwin_ctrl
  import vwin_pkg::*;
#(
  parameter int CNT_W = 11
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             regWrEn,
  input  logic [1:0]       regAddr,
  input  logic [31:0]      regWrData,
  output logic [31:0]      regRdData,
  input  logic             lineEnd,
  input  logic [CNT_W-1:0] lineCnt,
  output logic [CNT_W-1:0] reloadVal,
  output vwin_strobe_t     stb
);

  // Values written by software
  logic [CNT_W-1:0] pendStrt, pendStop, pendTotal;
  logic             pendSyncEn, pendComp;
  // Values in use for the current frame
  logic [CNT_W-1:0] effStrt, effStop;
  logic             effSyncEn, effComp;

  logic atZero;
  logic windowOk;
  logic unusedWrBits;

  assign unusedWrBits = ^regWrData;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendStrt   <= '0;
      pendStop   <= '0;
      pendTotal  <= '0;
      pendSyncEn <= 1'b0;
      pendComp   <= 1'b0;
    end else if (regWrEn) begin
      case (regAddr)
        ADDR_WINDOW: begin
          pendStrt <= regWrData[0 +: CNT_W];
          pendStop <= regWrData[STOP_LSB +: CNT_W];
        end
        ADDR_TOTAL: pendTotal <= regWrData[0 +: CNT_W];
        ADDR_MODE: begin
          pendSyncEn <= regWrData[0];
          pendComp   <= regWrData[1];
        end
        default: ;
      endcase
    end
  end

  assign atZero = (lineCnt == '0);

  // New settings come into use only on a frame boundary
  always_ff @(posedge clk) begin
    if (!rstN) begin
      effStrt   <= '0;
      effStop   <= '0;
      effSyncEn <= 1'b0;
      effComp   <= 1'b0;
    end else if (lineEnd && atZero) begin
      effStrt   <= pendStrt;
      effStop   <= pendStop;
      effSyncEn <= pendSyncEn;
      effComp   <= pendComp;
    end
  end

  assign windowOk     = (effStrt != effStop);
  assign stb.load     = lineEnd & atZero;
  assign stb.step     = lineEnd & ~atZero;
  assign stb.startHit = windowOk & (lineCnt == effStrt);
  assign stb.stopHit  = windowOk & (lineCnt == effStop);
  assign stb.syncGate = effSyncEn & ~effComp;
  assign reloadVal    = pendTotal;

  always_comb begin
    regRdData = '0;
    case (regAddr)
      ADDR_WINDOW: begin
        regRdData[0 +: CNT_W]        = pendStrt;
        regRdData[STOP_LSB +: CNT_W] = pendStop;
      end
      ADDR_TOTAL: regRdData[0 +: CNT_W] = pendTotal;
      ADDR_MODE:  regRdData[1:0] = {pendComp, pendSyncEn};
      default: ;
    endcase
  end

endmodule

// File: rtl/vwin_dp.sv
module vwin_dp
  import vwin_pkg::*;
#(
  parameter int CNT_W = 11
) (
  input  logic             clk,
  input  logic             rstN,
  input  vwin_strobe_t     stb,
  input  logic [CNT_W-1:0] reloadVal,
  output logic [CNT_W-1:0] lineCnt,
  output logic             vActive,
  output logic             vSync
);

  always_ff @(posedge clk) begin
    if (!rstN)         lineCnt <= '0;
    else if (stb.load) lineCnt <= reloadVal;
    else if (stb.step) lineCnt <= lineCnt - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN)             vActive <= 1'b0;
    else if (stb.startHit) vActive <= 1'b1;
    else if (stb.stopHit)  vActive <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rstN)             vSync <= 1'b0;
    else if (!stb.syncGate) vSync <= 1'b0;
    else if (stb.startHit) vSync <= 1'b1;
    else if (stb.stopHit)  vSync <= 1'b0;
  end

endmodule

// File: rtl/vwin_top.sv
module vwin_top
  import vwin_pkg::*;
#(
  parameter int CNT_W = 11  // at most 16 so both fields fit the window register
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        regWrEn,
  input  logic [1:0]  regAddr,
  input  logic [31:0] regWrData,
  output logic [31:0] regRdData,
  input  logic        lineEnd,
  input  logic        hActive,
  output logic        vActive,
  output logic        vSync,
  output logic        videoActive
);

  vwin_strobe_t     stb;
  logic [CNT_W-1:0] lineCnt;
  logic [CNT_W-1:0] reloadVal;

  vwin_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .lineEnd(lineEnd),
    .lineCnt(lineCnt), .reloadVal(reloadVal), .stb(stb)
  );

  vwin_dp #(.CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .reloadVal(reloadVal),
    .lineCnt(lineCnt), .vActive(vActive), .vSync(vSync)
  );

  assign videoActive = vActive | hActive;

endmodule

// File: rtl/vwin_checker.sv
module vwin_checker
  import vwin_pkg::*;
#(
  parameter int CNT_W = 11
) (
  input logic             clk,
  input logic             rstN,
  input logic [1:0]       regAddr,
  input logic [31:0]      regRdData,
  input logic             vActive,
  input logic             vSync,
  input logic [CNT_W-1:0] lineCnt,
  input logic [CNT_W-1:0] reloadVal,
  input vwin_strobe_t     stb
);

  localparam logic [31:0] FIELD_ONES = (32'd1 << CNT_W) - 32'd1;
  localparam logic [31:0] WIN_MASK   = FIELD_ONES | (FIELD_ONES << STOP_LSB);

  p_open_r2: assert property (@(posedge clk) disable iff (!rstN)
    stb.startHit |=> vActive);

  p_close_r3: assert property (@(posedge clk) disable iff (!rstN)
    (stb.stopHit && !stb.startHit) |=> !vActive);

  p_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    (!stb.startHit && !stb.stopHit) |=> $stable(vActive));

  p_gate_off_r5: assert property (@(posedge clk) disable iff (!rstN)
    !stb.syncGate |=> !vSync);

  p_sync_rise_r5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(vSync) |-> $past(stb.startHit));

  p_reserved_r7: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr == ADDR_WINDOW) |-> ((regRdData & ~WIN_MASK) == 32'd0));

  p_reload_r9: assert property (@(posedge clk) disable iff (!rstN)
    stb.load |=> (lineCnt == $past(reloadVal)));

  p_step_r9: assert property (@(posedge clk) disable iff (!rstN)
    stb.step |=> (lineCnt == $past(lineCnt) - 1'b1));

  p_excl_r9: assert property (@(posedge clk) disable iff (!rstN)
    !(stb.load && stb.step));

endmodule

bind vwin_top vwin_checker #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rstN(rstN), .regAddr(regAddr), .regRdData(regRdData),
  .vActive(vActive), .vSync(vSync), .lineCnt(lineCnt),
  .reloadVal(reloadVal), .stb(stb)
);

// File: tb/sim_vwin_top.sv
`timescale 1ns/1ps
module sim_vwin_top;

  localparam int CW = 4;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic [1:0]  regAddr = 2'd0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic        lineEnd = 1'b0;
  logic        hActive = 1'b0;
  logic        vActive, vSync, videoActive;

  int nVec = 0;
  int nBad = 0;

  // Reference model state
  int mCnt = 0, pS = 0, pP = 0, pT = 0, eS = 0, eP = 0;
  bit pEn = 0, pComp = 0, eGate = 0;
  bit mVa = 0, mVs = 0;

  always #5 clk = ~clk;

  vwin_top #(.CNT_W(CW)) u0 (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .lineEnd(lineEnd),
    .hActive(hActive), .vActive(vActive), .vSync(vSync),
    .videoActive(videoActive)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nVec++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
    case (a)
      2'd0: begin pS = d[CW-1:0]; pP = d[16 +: CW]; end
      2'd1: pT = d[CW-1:0];
      2'd2: begin pEn = d[0]; pComp = d[1]; end
      default: ;
    endcase
  endtask

  task automatic rdChk(input logic [1:0] a, input logic [31:0] exp, input string req);
    regAddr = a;
    #1;
    chk(req, regRdData, exp);
  endtask

  // One end-of-line pulse, then one idle cycle; outputs checked afterwards
  task automatic lineStep(input bit h);
    @(negedge clk);
    lineEnd = 1'b1; hActive = h;
    @(negedge clk);
    lineEnd = 1'b0;
    @(negedge clk);
    if (!eGate) mVs = 0;
    if (mCnt == 0) begin
      mCnt = pT; eS = pS; eP = pP; eGate = pEn && !pComp;
    end else begin
      mCnt = mCnt - 1;
    end
    if (eS != eP) begin
      if (mCnt == eS) mVa = 1;
      else if (mCnt == eP) mVa = 0;
    end
    if (!eGate) mVs = 0;
    else if (eS != eP && mCnt == eS) mVs = 1;
    else if (eS != eP && mCnt == eP) mVs = 0;
    chk("R2 R3 R4 R8 R9 vActive", {31'd0, vActive}, {31'd0, mVa});
    chk("R5 vSync", {31'd0, vSync}, {31'd0, mVs});
    chk("R6 videoActive", {31'd0, videoActive}, {31'd0, mVa | h});
  endtask

  initial begin
    #2_000_000;
    nBad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
    $finish;
  end

  initial begin
    int tots[3] = '{2, 5, 7};
    logic [31:0] fOnes;
    fOnes = (32'd1 << CW) - 32'd1;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk("R1 vActive", {31'd0, vActive}, 32'd0);
    chk("R1 vSync", {31'd0, vSync}, 32'd0);
    rdChk(2'd0, 32'd0, "R1 window reg");
    rdChk(2'd1, 32'd0, "R1 total reg");
    rdChk(2'd2, 32'd0, "R1 mode reg");
    // R7: reserved bits
    wr(2'd0, 32'hFFFF_FFFF);
    rdChk(2'd0, fOnes | (fOnes << 16), "R7 window reserved");
    wr(2'd1, 32'hFFFF_FFFF);
    rdChk(2'd1, fOnes, "R7 total reserved");
    wr(2'd2, 32'hFFFF_FFFF);
    rdChk(2'd2, 32'd3, "R7 mode reserved");
    // Start equal to stop: window stays as it is (R4)
    for (int k = 0; k < 20; k++) lineStep(k[0]);
    // Sweep line totals, start/stop pairs and modes
    foreach (tots[ti]) begin
      for (int s = 0; s <= tots[ti] + 1; s++) begin
        for (int p = 0; p <= tots[ti] + 1; p++) begin
          int md;
          md = (s + p + tots[ti]) % 4;
          wr(2'd1, tots[ti]);
          rdChk(2'd1, tots[ti], "R8 total readback");
          wr(2'd0, (p << 16) | s);
          rdChk(2'd0, (p << 16) | s, "R8 window readback");
          wr(2'd2, md);
          rdChk(2'd2, md, "R8 mode readback");
          for (int k = 0; k < 2 * (tots[ti] + 1) + 1; k++)
            lineStep(((k + s) % 3) == 0);
        end
      end
    end
    // Mid-frame rewrite must not disturb current frame (R8)
    wr(2'd0, (32'd1 << 16) | 32'd4);
    for (int k = 0; k < 3; k++) lineStep(1'b0);
    wr(2'd0, (32'd3 << 16) | 32'd6);
    for (int k = 0; k < 20; k++) lineStep(1'b0);
    $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
    $finish;
  end

endmodule